// File: doc/BRIEF.md
# Call and Return Stack Unit

This unit saves and restores a microcontroller core's program counter, and single register bytes, on a byte-wide stack held in data memory. The core raises a command code for one cycle. The unit then performs one data-memory access per clock, moves its 16-bit stack pointer after each access, and signals the end of the command with a one-cycle `done` pulse. Calls and returns also present the new program counter on `pc_out` with `pc_load`. A return-from-interrupt additionally raises `ie_set` so the core can set its global interrupt enable.

The program counter is a word address. A mode input selects its width: 16 bits (two stacked bytes) or 22 bits (three stacked bytes). The unit samples the mode when it accepts a command. A push writes at the pointer and then decrements it. A pop increments the pointer first and then reads. The pointer wraps modulo 2^16.

The sequencer is an enumerated state machine with these transitions:
- `ST_IDLE` goes to `ST_PUSH_LO` on any call.
- `ST_IDLE` goes to `ST_POP_EXT` (wide mode) or `ST_POP_HI` (narrow mode) on a return.
- `ST_IDLE` goes to `ST_PUSH_REG` on a push and to `ST_POP_REG` on a pop.
- `ST_PUSH_LO` goes to `ST_PUSH_HI`.
- `ST_PUSH_HI` goes to `ST_PUSH_EXT` in wide mode and to `ST_IDLE` otherwise.
- `ST_POP_EXT` goes to `ST_POP_HI`, and `ST_POP_HI` goes to `ST_POP_LO`.
- `ST_PUSH_EXT`, `ST_POP_LO`, `ST_PUSH_REG` and `ST_POP_REG` all return to `ST_IDLE`.

Top module: `callret_stack_unit`

## Requirements
- R1: While `rst_n` is low and at release, `sp` equals SP_INIT (default 0x08FF), `busy`, `done`, `pc_load` and `ie_set` are low, and `pc_out` and `pop_data` are zero.
- R2: A push (cmd_op=6) writes `push_data` at address `sp` in one cycle, and `sp` decrements by one at the end of that cycle.
- R3: A pop (cmd_op=7) takes one cycle: `sp` increments and the byte at the incremented address is read. The byte appears on `pop_data` with `done` and is held until the next pop.
- R4: A call (cmd_op=1 absolute, 2 indirect, 3 relative) pushes the masked `pc_next` in this order: bits 7:0, then bits 15:8, then, in wide mode (`wide_mode`=1), bits 23:16 with the unused upper bits zero. Each byte goes to the current `sp`.
- R5: A return (cmd_op=4) pops in the reverse order: bits 23:16 first (wide mode only), then 15:8, then 7:0. The reassembled value, masked to the mode, appears on `pc_out` with `pc_load` and `done`.
- R6: The call target is chosen by the command. Absolute uses `abs_target`. Indirect uses {`ind_ext`[5:0], `ind_ptr`} in wide mode and `ind_ptr` in narrow mode. Relative uses `pc_next` plus the sign-extended 12-bit `rel_off`. The target is masked to 16 bits (narrow) or 22 bits (wide) and appears on `pc_out` with `pc_load` at `done`.
- R7: A return-from-interrupt (cmd_op=5) behaves as R5 and also pulses `ie_set` in the same cycle as `pc_load`.
- R8: `busy` is high exactly during the byte cycles: 2 for a narrow call or return, 3 for a wide one, 1 for a push or pop. `done` is a one-cycle pulse in the cycle after the last byte, when `busy` is already low.
- R9: While `busy` is high, `cmd_op` and `sp_load` are ignored and changes on `wide_mode` have no effect on the command in progress.
- R10: `sp` wraps modulo 2^16: a push at 0x0000 leaves 0xFFFF, and a pop from 0xFFFF reads address 0x0000.
- R11: `sp_load` while idle writes `sp_wdata` into `sp`. A command accepted in the same cycle makes its first access relative to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1 selects the 22-bit program counter (three stacked bytes) |
| cmd_op | input | 3 | Command code, one cycle; 0 means none |
| pc_next | input | 22 | Address of the next instruction (return address) |
| abs_target | input | 22 | Absolute call target |
| ind_ptr | input | 16 | Indirect call pointer |
| ind_ext | input | 8 | Indirect call extension byte (wide mode) |
| rel_off | input | 12 | Signed relative call offset |
| push_data | input | 8 | Byte to push |
| sp_load | input | 1 | Load the stack pointer while idle |
| sp_wdata | input | 16 | Value for `sp_load` |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| mem_addr | output | 16 | Data-memory address |
| mem_wdata | output | 8 | Data-memory write byte |
| mem_rdata | input | 8 | Data-memory read byte, valid in the same cycle |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | `pc_out` carries a new program counter |
| pc_out | output | 22 | New program counter |
| ie_set | output | 1 | Return-from-interrupt completed |
| pop_data | output | 8 | Last popped byte |

## Verification
A corrupted state register or byte counter shows on the data-memory port within one cycle. The wrong strobe appears, an address fails to track `sp`, or a third byte is emitted in narrow mode. A wrong pointer update is visible on `sp` at the next clock edge, and it also misplaces every later access. A slip in byte order or reassembly survives until the matching return or pop, where `pc_out` or `pop_data` disagrees at the `done` pulse. For that reason, every call in the stimulus is later unwound and every comparison runs each cycle.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_CALL_ABS = 3'd1,
        OP_CALL_IND = 3'd2,
        OP_CALL_REL = 3'd3,
        OP_RET      = 3'd4,
        OP_RETI     = 3'd5,
        OP_PUSH     = 3'd6,
        OP_POP      = 3'd7
    } crs_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_PUSH_EXT,
        ST_POP_EXT,
        ST_POP_HI,
        ST_POP_LO,
        ST_PUSH_REG,
        ST_POP_REG
    } crs_state_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC,
        SP_LOAD
    } sp_act_e;

    function automatic logic is_call(crs_op_e op);
        return (op == OP_CALL_ABS) || (op == OP_CALL_IND) || (op == OP_CALL_REL);
    endfunction

endpackage

// File: rtl/crs_sp_reg.sv
module crs_sp_reg
    import crs_pkg::*;
#(
    parameter int             SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h08FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sp_act_e         act,
    input  logic [SP_W-1:0] load_val,
    output logic [SP_W-1:0] sp_q,
    output logic [SP_W-1:0] sp_up
);

    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else begin
            unique case (act)
                SP_DEC:  sp_q <= sp_q - ONE;
                SP_INC:  sp_q <= sp_q + ONE;
                SP_LOAD: sp_q <= load_val;
                default: sp_q <= sp_q;
            endcase
        end
    end

    assign sp_up = sp_q + ONE;

endmodule

// File: rtl/crs_target_gen.sv
module crs_target_gen
    import crs_pkg::*;
#(
    parameter int PC_W     = 22,
    parameter int NARROW_W = 16,
    parameter int PTR_W    = 16,
    parameter int OFF_W    = 12
) (
    input  crs_op_e          op,
    input  logic             wide,
    input  logic [PC_W-1:0]  pc_next,
    input  logic [PC_W-1:0]  abs_target,
    input  logic [PTR_W-1:0] ind_ptr,
    input  logic [7:0]       ind_ext,
    input  logic [OFF_W-1:0] rel_off,
    output logic [PC_W-1:0]  ret_addr,
    output logic [PC_W-1:0]  call_target
);

    localparam int EXT_W = PC_W - PTR_W;
    localparam logic [PC_W-1:0] NARROW_MASK =
        {{(PC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [PC_W-1:0] rel_ext;
    logic [PC_W-1:0] rel_sum;
    logic [PC_W-1:0] ind_full;
    logic [PC_W-1:0] raw_target;
    logic            unused_ext;

    assign rel_ext  = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
    assign rel_sum  = pc_next + rel_ext;
    assign ind_full = wide ? {ind_ext[EXT_W-1:0], ind_ptr}
                           : {{EXT_W{1'b0}}, ind_ptr};
    assign unused_ext = ^ind_ext[7:EXT_W];

    always_comb begin
        unique case (op)
            OP_CALL_IND: raw_target = ind_full;
            OP_CALL_REL: raw_target = rel_sum;
            default:     raw_target = abs_target;
        endcase
    end

    assign call_target = wide ? raw_target : (raw_target & NARROW_MASK);
    assign ret_addr    = wide ? pc_next    : (pc_next & NARROW_MASK);

endmodule

// File: rtl/callret_stack_unit.sv
module callret_stack_unit
    import crs_pkg::*;
#(
    parameter int              PC_W     = 22,
    parameter int              NARROW_W = 16,
    parameter int              SP_W     = 16,
    parameter int              PTR_W    = 16,
    parameter int              OFF_W    = 12,
    parameter logic [SP_W-1:0] SP_INIT  = 16'h08FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic [2:0]       cmd_op,
    input  logic [PC_W-1:0]  pc_next,
    input  logic [PC_W-1:0]  abs_target,
    input  logic [PTR_W-1:0] ind_ptr,
    input  logic [7:0]       ind_ext,
    input  logic [OFF_W-1:0] rel_off,
    input  logic [7:0]       push_data,
    input  logic             sp_load,
    input  logic [SP_W-1:0]  sp_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic [SP_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    output logic [SP_W-1:0]  sp,
    output logic             busy,
    output logic             done,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_out,
    output logic             ie_set,
    output logic [7:0]       pop_data
);

    localparam int EXT_W = PC_W - 16;
    localparam int HI_W  = PC_W - 8;
    localparam logic [PC_W-1:0] NARROW_MASK =
        {{(PC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    crs_state_e      state_q, state_d;
    crs_op_e         op_in, op_q;
    sp_act_e         sp_act;
    logic            wide_q;
    logic [PC_W-1:0] ret_q, tgt_q;
    logic [PC_W-1:0] ret_addr, call_target;
    logic [7:0]      push_q;
    logic [HI_W-1:0] pop_acc;
    logic [PC_W-1:0] ret_pc;
    logic [SP_W-1:0] sp_up;
    logic            accept;
    logic            finish;

    assign op_in  = crs_op_e'(cmd_op);
    assign accept = (state_q == ST_IDLE) && (op_in != OP_NONE);

    crs_sp_reg #(
        .SP_W    (SP_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (sp_act),
        .load_val (sp_wdata),
        .sp_q     (sp),
        .sp_up    (sp_up)
    );

    crs_target_gen #(
        .PC_W     (PC_W),
        .NARROW_W (NARROW_W),
        .PTR_W    (PTR_W),
        .OFF_W    (OFF_W)
    ) u_tgt (
        .op          (op_in),
        .wide        (wide_mode),
        .pc_next     (pc_next),
        .abs_target  (abs_target),
        .ind_ptr     (ind_ptr),
        .ind_ext     (ind_ext),
        .rel_off     (rel_off),
        .ret_addr    (ret_addr),
        .call_target (call_target)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (is_call(op_in))                       state_d = ST_PUSH_LO;
                    else if (op_in == OP_RET || op_in == OP_RETI)
                        state_d = wide_mode ? ST_POP_EXT : ST_POP_HI;
                    else if (op_in == OP_PUSH)                state_d = ST_PUSH_REG;
                    else                                      state_d = ST_POP_REG;
                end
            end
            ST_PUSH_LO:  state_d = ST_PUSH_HI;
            ST_PUSH_HI:  state_d = wide_q ? ST_PUSH_EXT : ST_IDLE;
            ST_PUSH_EXT: state_d = ST_IDLE;
            ST_POP_EXT:  state_d = ST_POP_HI;
            ST_POP_HI:   state_d = ST_POP_LO;
            ST_POP_LO:   state_d = ST_IDLE;
            ST_PUSH_REG: state_d = ST_IDLE;
            ST_POP_REG:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Memory port and pointer action by state
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = 8'h00;
        finish    = 1'b0;
        unique case (state_q)
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_wdata = ret_q[7:0];
            end
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_wdata = ret_q[15:8];
                finish    = !wide_q;
            end
            ST_PUSH_EXT: begin
                mem_we    = 1'b1;
                mem_wdata = {{(8-EXT_W){1'b0}}, ret_q[PC_W-1:16]};
                finish    = 1'b1;
            end
            ST_PUSH_REG: begin
                mem_we    = 1'b1;
                mem_wdata = push_q;
                finish    = 1'b1;
            end
            ST_POP_EXT, ST_POP_HI: mem_re = 1'b1;
            ST_POP_LO, ST_POP_REG: begin
                mem_re = 1'b1;
                finish = 1'b1;
            end
            default: ;
        endcase
        if (mem_we)                             sp_act = SP_DEC;
        else if (mem_re)                        sp_act = SP_INC;
        else if (state_q == ST_IDLE && sp_load) sp_act = SP_LOAD;
        else                                    sp_act = SP_HOLD;
    end

    assign mem_addr = mem_re ? sp_up : sp;
    assign busy     = (state_q != ST_IDLE);
    assign ret_pc   = {pop_acc, mem_rdata};

    // Command latch, pop accumulator and completion outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            wide_q   <= 1'b0;
            ret_q    <= '0;
            tgt_q    <= '0;
            push_q   <= 8'h00;
            pop_acc  <= '0;
            done     <= 1'b0;
            pc_load  <= 1'b0;
            ie_set   <= 1'b0;
            pc_out   <= '0;
            pop_data <= 8'h00;
        end else begin
            done    <= finish;
            pc_load <= 1'b0;
            ie_set  <= 1'b0;
            if (accept) begin
                op_q    <= op_in;
                wide_q  <= wide_mode;
                ret_q   <= ret_addr;
                tgt_q   <= call_target;
                push_q  <= push_data;
                pop_acc <= '0;
            end else if (mem_re) begin
                pop_acc <= {pop_acc[HI_W-9:0], mem_rdata};
            end
            if (finish) begin
                if (is_call(op_q)) begin
                    pc_load <= 1'b1;
                    pc_out  <= tgt_q;
                end else if (op_q == OP_RET || op_q == OP_RETI) begin
                    pc_load <= 1'b1;
                    pc_out  <= wide_q ? ret_pc : (ret_pc & NARROW_MASK);
                    ie_set  <= (op_q == OP_RETI);
                end else if (op_q == OP_POP) begin
                    pop_data <= mem_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/callret_stack_checks.sv
module callret_stack_checks #(
    parameter int PC_W = 22,
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic [SP_W-1:0] sp,
    input logic            busy,
    input logic            done,
    input logic            pc_load,
    input logic [PC_W-1:0] pc_out,
    input logic            ie_set,
    input logic            wide_q
);

    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp);

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - ONE);

    assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == sp + ONE);

    assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp == $past(sp) + ONE);

    assert_narrow_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !wide_q) |-> pc_out[PC_W-1:16] == '0);

    assert_reti_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set |-> (pc_load && done));

    assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re));

endmodule

bind callret_stack_unit callret_stack_checks #(
    .PC_W (PC_W),
    .SP_W (SP_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp       (sp),
    .busy     (busy),
    .done     (done),
    .pc_load  (pc_load),
    .pc_out   (pc_out),
    .ie_set   (ie_set),
    .wide_q   (wide_q)
);

// File: tb/callret_stack_unit_bench.sv
module callret_stack_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SP_INIT    = 'h08FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [21:0] pc_next = '0, abs_target = '0;
    logic [15:0] ind_ptr = '0;
    logic [7:0]  ind_ext = '0, push_data = '0;
    logic [11:0] rel_off = '0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_wdata = '0;
    logic        mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] sp;
    logic        busy, done, pc_load, ie_set;
    logic [21:0] pc_out;
    logic [7:0]  pop_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    callret_stack_unit u_callret_stack_unit (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cmd_op(cmd_op),
        .pc_next(pc_next), .abs_target(abs_target), .ind_ptr(ind_ptr),
        .ind_ext(ind_ext), .rel_off(rel_off), .push_data(push_data),
        .sp_load(sp_load), .sp_wdata(sp_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sp(sp), .busy(busy), .done(done),
        .pc_load(pc_load), .pc_out(pc_out), .ie_set(ie_set),
        .pop_data(pop_data)
    );

    // Data memory seen by the design
    logic [7:0] bmem [int];
    always @(posedge clk) if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    always @(negedge clk)
        mem_rdata = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;

    // Behavioural reference model
    int    m_mem [int];
    int    m_ops [$];        // >=0: byte to write, -1: read
    int    m_sp = SP_INIT, m_kind = 0, m_wide = 0, m_tgt = 0, m_acc = 0;
    int    e_done = 0, e_pcl = 0, e_ie = 0, e_pc = 0, e_pop = 0;
    string scen = "R1";
    int    tests = 0, fails = 0, cyc = 0;
    bit    cmp_en = 0;

    function automatic int pmask(int w);
        return w ? 'h3FFFFF : 'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ops.delete();
            m_sp = SP_INIT; m_acc = 0; e_done = 0; e_pcl = 0; e_ie = 0;
            e_pc = 0; e_pop = 0;
        end else begin
            e_done = 0; e_pcl = 0; e_ie = 0;
            if (m_ops.size() > 0) begin
                int ev;
                ev = m_ops.pop_front();
                if (ev >= 0) begin
                    m_mem[m_sp] = ev;
                    m_sp = (m_sp - 1) & 'hFFFF;
                end else begin
                    m_sp = (m_sp + 1) & 'hFFFF;
                    m_acc = (m_acc << 8) | (m_mem.exists(m_sp) ? m_mem[m_sp] : 0);
                end
                if (m_ops.size() == 0) begin
                    e_done = 1;
                    if (m_kind >= 1 && m_kind <= 3) begin e_pcl = 1; e_pc = m_tgt; end
                    else if (m_kind == 4 || m_kind == 5) begin
                        e_pcl = 1; e_pc = m_acc & pmask(m_wide); e_ie = (m_kind == 5);
                    end else if (m_kind == 7) e_pop = m_acc & 'hFF;
                end
            end else begin
                if (sp_load) m_sp = int'(sp_wdata);
                if (cmd_op != 0) begin
                    int ra, so;
                    m_kind = int'(cmd_op); m_wide = int'(wide_mode); m_acc = 0;
                    ra = int'(pc_next) & pmask(m_wide);
                    so = (int'(rel_off) >= 2048) ? int'(rel_off) - 4096 : int'(rel_off);
                    case (m_kind)
                        1: m_tgt = int'(abs_target) & pmask(m_wide);
                        2: m_tgt = (m_wide ? ((int'(ind_ext) & 'h3F) << 16) : 0) | int'(ind_ptr);
                        3: m_tgt = (int'(pc_next) + so) & pmask(m_wide);
                        default: m_tgt = 0;
                    endcase
                    if (m_kind <= 3) begin
                        m_ops.push_back(ra & 'hFF);
                        m_ops.push_back((ra >> 8) & 'hFF);
                        if (m_wide) m_ops.push_back((ra >> 16) & 'hFF);
                    end else if (m_kind <= 5) begin
                        m_ops.push_back(-1); m_ops.push_back(-1);
                        if (m_wide) m_ops.push_back(-1);
                    end else if (m_kind == 6) m_ops.push_back(int'(push_data));
                    else m_ops.push_back(-1);
                end
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", scen, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            int eb, ew, er;
            eb = (m_ops.size() > 0);
            ew = eb && (m_ops[0] >= 0);
            er = eb && (m_ops[0] < 0);
            chk("busy (R8)", int'(busy), eb);
            chk("mem_we", int'(mem_we), ew);
            chk("mem_re", int'(mem_re), er);
            if (ew) begin
                chk("write addr", int'(mem_addr), m_sp);
                chk("write data", int'(mem_wdata), m_ops[0]);
            end
            if (er) chk("read addr", int'(mem_addr), (m_sp + 1) & 'hFFFF);
            chk("sp", int'(sp), m_sp);
            chk("done (R8)", int'(done), e_done);
            chk("pc_load", int'(pc_load), e_pcl);
            chk("ie_set", int'(ie_set), e_ie);
            chk("pc_out", int'(pc_out), e_pc);
            chk("pop_data", int'(pop_data), e_pop);
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic send(int op);
        @(negedge clk); #1;
        cmd_op = op[2:0];
        @(negedge clk); #1;
        cmd_op = 3'd0; sp_load = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        // R1: reset values observed during and after reset
        repeat (2) @(negedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R2: register pushes
        scen = "R2";
        push_data = 8'hA5; send(6); settle();
        push_data = 8'h3C; send(6); settle();

        // R3: pops return the bytes in reverse
        scen = "R3";
        send(7); settle();
        send(7); settle();

        // R4 and R6: narrow absolute call, target masked to 16 bits
        scen = "R4";
        wide_mode = 0; pc_next = 22'h00_0456; abs_target = 22'h31234;
        send(1); settle();
        // R5: narrow return restores 0x0456
        scen = "R5";
        send(4); settle();

        // R4 wide: three bytes; R7 return-from-interrupt
        scen = "R4";
        wide_mode = 1; pc_next = 22'h3F0102; abs_target = 22'h2ABCDE;
        send(1); settle();
        scen = "R7";
        send(5); settle();

        // R6: indirect calls, wide and narrow, then unwind
        scen = "R6";
        ind_ext = 8'h15; ind_ptr = 16'hBEEF; pc_next = 22'h123456;
        send(2); settle(); send(4); settle();
        wide_mode = 0;
        send(2); settle(); send(4); settle();
        // R6: relative calls, negative offset narrow, positive offset wide
        pc_next = 22'h000010; rel_off = 12'h800;
        send(3); settle(); send(5); settle();
        wide_mode = 1; pc_next = 22'h3FFFF0; rel_off = 12'h7FF;
        send(3); settle(); send(4); settle();

        // R9: commands, pointer load and mode change while busy
        scen = "R9";
        wide_mode = 1; pc_next = 22'h2A0B0C; abs_target = 22'h001000;
        @(negedge clk); #1 cmd_op = 3'd1;
        @(negedge clk); #1 cmd_op = 3'd7; sp_load = 1'b1; sp_wdata = 16'h0123; wide_mode = 0;
        @(negedge clk); #1 cmd_op = 3'd6;
        @(negedge clk); #1 cmd_op = 3'd0; sp_load = 1'b0;
        settle();
        wide_mode = 1; send(4); settle();

        // R10: wrap below zero and back
        scen = "R10";
        sp_load = 1'b1; sp_wdata = 16'h0000;
        @(negedge clk); #1; @(negedge clk); #1 sp_load = 1'b0;
        push_data = 8'h77; send(6); settle();
        send(7); settle();

        // R11: load and command accepted in the same cycle
        scen = "R11";
        sp_load = 1'b1; sp_wdata = 16'h0400; push_data = 8'hC3;
        send(6); settle();
        sp_load = 1'b1; sp_wdata = 16'h03FF;
        send(7); settle();

        // R5: push bytes by hand, then a narrow return pops them
        scen = "R5";
        wide_mode = 0;
        push_data = 8'h9A; send(6); settle();
        push_data = 8'h5E; send(6); settle();
        send(4); settle();

        finish_run();
    end

endmodule